// File: doc/BRIEF.md
# Vertical Charge Sweep Sequencer

This block clears leftover charge out of the vertical shift registers of an interline image sensor before a frame-mode readout. It does this by clocking a long, fast burst of vertical transfers. After a sweep request, it waits a set number of line strobes. It then steps four vertical phase clocks through a fixed rotation. The steps fall on a pixel-clock grid inside each line, and they continue across as many lines as the stage total needs.

The sequencer has no timer of its own for pixels or lines. It follows the pixel count and the line strobe that the timing generator already produces. Every edge therefore stays locked to the line structure. With the default parameters, one stage takes 80 pixel clocks and 33 stages fit in a line. The 2112 stages fill 64 lines, starting on the second line after the request. A busy flag covers the whole operation, from the accepted request to the end of the last stage. A one-cycle completion pulse marks that end. Phases 1 and 3 each have two output pins, and each pair carries the same waveform.

Top module: `charge_sweep_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `busy` and `done` are 0, and the phases are at rest: phases 1 and 2 are high, and phases 3 and 4 are low.
- R2: While idle, the phases stay at rest and `busy` is 0. A `sweep_req` sampled while idle sets `busy` on the next cycle.
- R3: After a request is accepted, the sweep arms on the ARM_LINES-th (default 2) `line_stb` that is sampled after the acceptance edge. A strobe in the same cycle as the accepted request is not counted. The phases do not move before arming.
- R4: While sweeping, the phases advance one step in the cycle after each sampled cycle in which `pix_cnt` equals EDGE_OFS + k*EDGE_STEP, for a whole number k ≥ 0. They do not change in any other cycle. The grid restarts at every `line_stb`.
- R5: The phase pairs that are high follow the order {1,2} → {2,3} → {3,4} → {4,1} → {1,2}. In each step, one phase falls and one phase rises. Four steps make one stage.
- R6: `vph1a` always equals `vph1b`, and `vph3a` always equals `vph3b`.
- R7: A sweep performs exactly N_STAGES stages (4*N_STAGES phase steps) and continues across line boundaries until they are done.
- R8: `done` is high for exactly one cycle. That cycle is the one in which the phases return to rest after the last step. `busy` falls in that same cycle.
- R9: A `sweep_req` that arrives while `busy` is high is ignored, and the running sweep still makes exactly N_STAGES stages. A request sampled in the cycle that shows `done` is accepted.
- R10: When two adjacent phases are both high, they stay high together for at least MIN_OVERLAP cycles. This holds for any EDGE_STEP ≥ MIN_OVERLAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sweep_req | input | 1 | Request to start a sweep; accepted only while idle |
| line_stb | input | 1 | One-cycle line strobe, aligned with `pix_cnt` = 0 |
| pix_cnt | input | $clog2(LINE_CLKS) | Pixel position within the current line |
| vph1a | output | 1 | Vertical phase 1, half A |
| vph1b | output | 1 | Vertical phase 1, half B |
| vph2 | output | 1 | Vertical phase 2 |
| vph3a | output | 1 | Vertical phase 3, half A |
| vph3b | output | 1 | Vertical phase 3, half B |
| vph4 | output | 1 | Vertical phase 4 |
| busy | output | 1 | High from the accepted request until completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench starts one request in the middle of a line. It starts another in the same cycle as a line strobe. A design that counted that strobe toward arming would begin the sweep one line early.

A request is held high through most of a sweep. A design that restarted or extended the sweep on that request would produce more than 4*N_STAGES phase steps or a second completion pulse. A new request is also given in the very cycle that shows `done`. A design that kept `busy` one cycle too long would drop that request.

Every cycle is compared against the arithmetic edge grid. An off-by-one in the grid comparator or in the stage counter shows up as a shifted phase step, or as a sweep that ends one stage early or late. The shortest adjacent-phase overlap observed is also measured against the step pitch.

// File: rtl/charge_sweep_pkg.sv
package charge_sweep_pkg;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_ARM  = 2'd1,
    SW_RUN  = 2'd2
  } sweep_state_t;

  // Bit i carries vertical phase i+1.
  typedef logic [3:0] phase_vec_t;

  localparam phase_vec_t PH_REST = 4'b0011;  // phases 1 and 2 high
  localparam phase_vec_t PH_LAST = 4'b1001;  // phases 4 and 1 high

  // One step of the rotation: the high pair moves up by one phase.
  function automatic phase_vec_t phase_step(input phase_vec_t cur);
    return {cur[2:0], cur[3]};
  endfunction

endpackage

// File: rtl/sweep_edge_grid.sv
module sweep_edge_grid #(
  parameter int LINE_CLKS = 2640,
  parameter int EDGE_OFS  = 16,
  parameter int EDGE_STEP = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         line_stb,
  input  logic [$clog2(LINE_CLKS)-1:0] pix_cnt,
  output logic                         edge_hit
);

  localparam int EDGE_W = $clog2(LINE_CLKS + EDGE_STEP);
  localparam logic [EDGE_W-1:0] OFS_V  = EDGE_W'(EDGE_OFS);
  localparam logic [EDGE_W-1:0] STEP_V = EDGE_W'(EDGE_STEP);

  // Position of the next grid point; it walks forward by one pitch per hit,
  // so no divider or modulo is needed against the pixel count.
  logic [EDGE_W-1:0] next_q;

  assign edge_hit = !line_stb && (EDGE_W'(pix_cnt) == next_q);

  always_ff @(posedge clk) begin
    if (rst || line_stb) begin
      next_q <= OFS_V;
    end else if (edge_hit) begin
      next_q <= next_q + STEP_V;
    end
  end

endmodule

// File: rtl/sweep_phase_ring.sv
module sweep_phase_ring
  import charge_sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output phase_vec_t phases,
  output logic       stage_end
);

  phase_vec_t ph_q;

  assign phases    = ph_q;
  assign stage_end = adv && (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_REST;
    end else if (adv) begin
      ph_q <= phase_step(ph_q);
    end
  end

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import charge_sweep_pkg::*;
#(
  parameter int N_STAGES  = 2112,
  parameter int ARM_LINES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic line_stb,
  input  logic stage_end,
  output logic sweeping,
  output logic busy,
  output logic done
);

  localparam int STAGE_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;
  localparam int LINE_W  = $clog2(ARM_LINES + 1);
  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(N_STAGES - 1);
  localparam logic [LINE_W-1:0]  LAST_ARM   = LINE_W'(ARM_LINES - 1);

  sweep_state_t        state_q;
  logic [STAGE_W-1:0]  stage_q;
  logic [LINE_W-1:0]   lines_q;

  assign sweeping = (state_q == SW_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SW_IDLE;
      stage_q <= '0;
      lines_q <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SW_IDLE: begin
          if (req) begin
            state_q <= SW_ARM;
            lines_q <= '0;
            stage_q <= '0;
            busy    <= 1'b1;
          end
        end
        SW_ARM: begin
          if (line_stb) begin
            if (lines_q == LAST_ARM) begin
              state_q <= SW_RUN;
            end else begin
              lines_q <= lines_q + 1'b1;
            end
          end
        end
        SW_RUN: begin
          if (stage_end) begin
            if (stage_q == LAST_STAGE) begin
              state_q <= SW_IDLE;
              stage_q <= '0;
              busy    <= 1'b0;
              done    <= 1'b1;
            end else begin
              stage_q <= stage_q + 1'b1;
            end
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/charge_sweep_seq.sv
module charge_sweep_seq
  import charge_sweep_pkg::*;
#(
  parameter int N_STAGES    = 2112,
  parameter int LINE_CLKS   = 2640,
  parameter int EDGE_OFS    = 16,
  parameter int EDGE_STEP   = 20,
  parameter int ARM_LINES   = 2,
  parameter int MIN_OVERLAP = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sweep_req,
  input  logic                         line_stb,
  input  logic [$clog2(LINE_CLKS)-1:0] pix_cnt,
  output logic                         vph1a,
  output logic                         vph1b,
  output logic                         vph2,
  output logic                         vph3a,
  output logic                         vph3b,
  output logic                         vph4,
  output logic                         busy,
  output logic                         done
);

  logic       edge_hit;
  logic       sweeping;
  logic       stage_end;
  phase_vec_t phases;

  sweep_edge_grid #(
    .LINE_CLKS (LINE_CLKS),
    .EDGE_OFS  (EDGE_OFS),
    .EDGE_STEP (EDGE_STEP)
  ) u_grid (
    .clk      (clk),
    .rst      (rst),
    .line_stb (line_stb),
    .pix_cnt  (pix_cnt),
    .edge_hit (edge_hit)
  );

  sweep_phase_ring u_ring (
    .clk       (clk),
    .rst       (rst),
    .adv       (sweeping && edge_hit),
    .phases    (phases),
    .stage_end (stage_end)
  );

  sweep_ctrl #(
    .N_STAGES  (N_STAGES),
    .ARM_LINES (ARM_LINES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req       (sweep_req),
    .line_stb  (line_stb),
    .stage_end (stage_end),
    .sweeping  (sweeping),
    .busy      (busy),
    .done      (done)
  );

  // Split halves of phases 1 and 3 share one register each.
  assign vph1a = phases[0];
  assign vph1b = phases[0];
  assign vph2  = phases[1];
  assign vph3a = phases[2];
  assign vph3b = phases[2];
  assign vph4  = phases[3];

endmodule

// File: rtl/charge_sweep_chk.sv
module charge_sweep_chk #(
  parameter int MIN_OVERLAP = 20
) (
  input logic clk,
  input logic rst,
  input logic sweep_req,
  input logic busy,
  input logic done,
  input logic vph1a,
  input logic vph2,
  input logic vph3a,
  input logic vph4
);

  localparam int CW = $clog2(MIN_OVERLAP + 1);

  logic [3:0] ph;
  assign ph = {vph4, vph3a, vph2, vph1a};

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_rest_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ph == 4'b0011));

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sweep_req));

  p_two_edges_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(ph ^ $past(ph)) == 0) || ($countones(ph ^ $past(ph)) == 2));

  for (genvar i = 0; i < 4; i++) begin : g_pair
    logic          ovl_now;
    logic          ovl_q;
    logic [CW-1:0] cnt_q;

    assign ovl_now = ph[i] & ph[(i + 1) % 4];

    always_ff @(posedge clk) begin
      if (rst) begin
        ovl_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        ovl_q <= ovl_now;
        if (!ovl_now) begin
          cnt_q <= '0;
        end else if (cnt_q < CW'(MIN_OVERLAP)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    p_overlap_r10: assert property (@(posedge clk) disable iff (rst)
      (ovl_q && !ovl_now) |-> (cnt_q >= CW'(MIN_OVERLAP)));
  end

endmodule

bind charge_sweep_seq charge_sweep_chk #(
  .MIN_OVERLAP (MIN_OVERLAP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sweep_req (sweep_req),
  .busy      (busy),
  .done      (done),
  .vph1a     (vph1a),
  .vph2      (vph2),
  .vph3a     (vph3a),
  .vph4      (vph4)
);

// File: tb/test_charge_sweep_seq.sv
`timescale 1ns/1ps
module test_charge_sweep_seq;

  localparam int N    = 7;
  localparam int LINE = 100;
  localparam int OFS  = 6;
  localparam int STEP = 10;
  localparam int ARM  = 2;
  localparam int MINO = 10;
  localparam int PW   = $clog2(LINE);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          stb = 1'b0;
  logic [PW-1:0] pix = '0;
  logic vph1a, vph1b, vph2, vph3a, vph3b, vph4, busy, done;

  charge_sweep_seq #(
    .N_STAGES (N), .LINE_CLKS (LINE), .EDGE_OFS (OFS),
    .EDGE_STEP (STEP), .ARM_LINES (ARM), .MIN_OVERLAP (MINO)
  ) i_charge_sweep_seq (
    .clk (clk), .rst (rst), .sweep_req (req), .line_stb (stb), .pix_cnt (pix),
    .vph1a (vph1a), .vph1b (vph1b), .vph2 (vph2), .vph3a (vph3a),
    .vph3b (vph3b), .vph4 (vph4), .busy (busy), .done (done)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int mode = 0;
  int lines = 0;
  int ticks = 0;
  int pcount = 0;
  int run_edges = 0;
  int run_dones = 0;
  int min_ovl = 1 << 30;
  int ovl_run [4];
  bit exp_done = 0;
  bit finished = 0;
  logic [3:0] prev_ph = 4'b0011;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ph_of(input int t);
    case (t % 4)
      0:       return 4'b0011;
      1:       return 4'b0110;
      2:       return 4'b1100;
      default: return 4'b1001;
    endcase
  endfunction

  // One clock: apply inputs, derive the expectation, sample after the edge.
  task automatic cyc(input bit st);
    string tag;
    logic [3:0] ph;
    req = st;
    pix = PW'(pcount);
    stb = (pcount == 0);
    exp_done = 0;
    case (mode)
      0: if (st) begin
           mode = 1; lines = 0; run_edges = 0; run_dones = 0;
         end
      1: if (pcount == 0) begin
           if (lines == ARM - 1) begin mode = 2; ticks = 0; end
           else lines++;
         end
      default: if (pcount >= OFS && (pcount - OFS) % STEP == 0) begin
           ticks++;
           if (ticks == 4 * N) begin mode = 0; exp_done = 1; end
         end
    endcase
    tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
    @(negedge clk);
    ph = {vph4, vph3a, vph2, vph1a};
    chk({tag, " phases"}, ph, (mode == 2) ? ph_of(ticks) : 4'b0011);
    chk("R6 phase1 halves", vph1b, vph1a);
    chk("R6 phase3 halves", vph3b, vph3a);
    chk("R8 done", done, exp_done);
    chk("R2 busy", busy, mode != 0);
    if (ph != prev_ph) run_edges++;
    if (done) run_dones++;
    for (int i = 0; i < 4; i++) begin
      if (ph[i] && ph[(i + 1) % 4]) ovl_run[i]++;
      else begin
        if (ovl_run[i] > 0 && ovl_run[i] < min_ovl) min_ovl = ovl_run[i];
        ovl_run[i] = 0;
      end
    end
    prev_ph = ph;
    pcount = (pcount + 1) % LINE;
  endtask

  task automatic run_to_done(input bit hold);
    int guard = 0;
    do begin
      cyc(hold);
      guard++;
    end while (!exp_done && guard < 5000);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ovl_run[i] = 0;
    for (int i = 0; i < 4; i++) begin
      pix = PW'(pcount);
      stb = (pcount == 0);
      @(negedge clk);
      pcount = (pcount + 1) % LINE;
    end
    rst = 1'b0;
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 rest phases", {vph4, vph3a, vph2, vph1a}, 4'b0011);

    // Request mid-line, single extra request injected during the sweep.
    repeat (25) cyc(0);
    cyc(1);
    repeat (120) cyc(0);
    cyc(1);
    run_to_done(0);
    chk("R7 steps in sweep", run_edges, 4 * N);
    chk("R8 done pulses", run_dones, 1);
    repeat (10) cyc(0);

    // Request in the strobe cycle, then held high through most of the sweep.
    while (pcount != 0) cyc(0);
    cyc(1);
    repeat (150) cyc(1);
    run_to_done(0);
    chk("R9 steps with held request", run_edges, 4 * N);
    chk("R9 done pulses with held request", run_dones, 1);

    // Request in the same cycle the completion pulse is visible.
    cyc(1);
    chk("R9 accepted at done", busy, 1);
    run_to_done(0);
    chk("R9 steps back to back", run_edges, 4 * N);
    repeat (5) cyc(0);
    chk("R10 shortest overlap", min_ovl, STEP);
    chk("R10 overlap floor", int'(min_ovl >= MINO), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule